// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block keeps a DRAM's contents alive by spreading the refresh of every row evenly over the retention window. A free-running interval timer produces one refresh credit per row slot. Credits collect in a small backlog counter. A sequencer turns each credit into one refresh cycle on the RAS/CAS strobes. Two sequences are available. In CAS-first mode, CAS falls ahead of RAS and the DRAM picks the row itself, so no address is driven. In row-addressed mode, CAS stays high and the scheduler drives the row from its own wrapping row counter.

The scheduler shares the DRAM bus with a normal access port. It asks for the bus with `ref_req` and takes it only when the access port reports idle. When the backlog is full, refresh wins the next decision whatever the access port reports. In that case `acc_hold` tells the access port to stay off the bus. In CAS-first mode a queued backlog can drain back to back: CAS stays low and only RAS is cycled.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low and in the first cycle after it, `ras_n` and `cas_n` are 1, and `addr_en`, `pending`, `row_addr`, `ref_req`, `ref_busy` and `acc_hold` are 0.
- R2: Refresh credits arrive exactly every INTERVAL = CLK_KHZ*RETENTION_MS/ROWS clocks (781 at the defaults). In steady state with the access port idle, any window of 20*INTERVAL clocks holds exactly 20 falling edges of `ras_n`.
- R3: Row-addressed mode (`mode_cbr`=0) works as follows. `cas_n` stays 1. `addr_en` is 1 and `row_addr` is stable for T_LEAD clocks before `ras_n` falls and stays so while `ras_n` is low.
- R4: CAS-first mode (`mode_cbr`=1) works as follows. `cas_n` is 0 for T_LEAD clocks before `ras_n` falls and stays 0 while `ras_n` is low. `addr_en` stays 0.
- R5: `pending` never exceeds MAX_PENDING (8). `acc_hold` is 1 exactly when `pending` equals MAX_PENDING.
- R6: `ras_n` is low for exactly T_RAS clocks per refresh. It is then high for T_RP clocks, during which `ref_busy` stays 1.
- R7: A refresh starts (`ref_busy` rises) only if `pending` was nonzero and either `acc_busy` was 0 or `pending` was at MAX_PENDING in the cycle before. `ref_req` is 1 exactly when `pending` is nonzero.
- R8: `row_addr` advances by one, modulo ROWS, at the end of each row-addressed refresh. It never changes otherwise.
- R9: In CAS-first mode, if at the end of precharge the mode is still CAS-first and another start is allowed, `ras_n` falls again at once and `cas_n` stays 0 across both refreshes.
- R10: `pending` drops by one on each refresh start and rises by one on each credit. A credit that arrives while `pending` is full and no start happens is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cbr | input | 1 | 1 = CAS-first refresh, 0 = row-addressed refresh; sampled at each start |
| acc_busy | input | 1 | Access port is using or wants the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_en | output | 1 | Scheduler is driving `row_addr` onto the address bus |
| row_addr | output | 9 | Row for row-addressed refresh |
| pending | output | 4 | Refresh credits not yet served |
| ref_req | output | 1 | Refresh wants the bus |
| ref_busy | output | 1 | A refresh cycle owns the bus |
| acc_hold | output | 1 | Backlog full: access port must not start |

## Verification
A start decision made in one cycle appears on `ref_busy`, `cas_n` and `addr_en` one clock later. `ras_n` follows after a further T_LEAD clocks, and `pending` reflects both credits and starts one clock after the cycle that caused them. The bench's behavioural model advances on each rising edge from the same inputs. All outputs are compared with the model on the falling edge, half a clock after the registers settle. The directed checks sample at those same falling edges, counting the one-clock registration delay.

// File: rtl/refresh_pkg.sv
// Package: shared types for the refresh scheduler.
// Assumes: nothing beyond the standard language.
package refresh_pkg;

    // Phases of one refresh cycle on the strobes.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_PRECH  = 2'd3
    } ref_phase_e;

endpackage

// File: rtl/refresh_interval_timer.sv
// Module: refresh_interval_timer
// Emits a one-clock credit pulse every INTERVAL clocks, the first one
// INTERVAL clocks after reset release.
// Assumes: INTERVAL >= 2.
module refresh_interval_timer #(
    parameter int unsigned INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

    logic [TW-1:0] remain;

    // Credit pulse when the countdown reaches zero.
    always_comb tick = (remain == '0);

    // Countdown with reload on every credit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= RELOAD;
        else if (tick)
            remain <= RELOAD;
        else
            remain <= remain - 1'b1;
    end
endmodule

// File: rtl/refresh_backlog.sv
// Module: refresh_backlog
// Counts refresh credits not yet served. It saturates at MAX_PENDING:
// a credit arriving at full with no simultaneous start is dropped.
// Assumes: take is asserted only while pending is nonzero.
module refresh_backlog #(
    parameter int unsigned MAX_PENDING = 8,
    parameter int unsigned PEND_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              take,
    output logic [PEND_W-1:0] pending,
    output logic              full,
    output logic              nonzero
);
    localparam logic [PEND_W-1:0] LIMIT = PEND_W'(MAX_PENDING);

    logic inc;

    // Status decode and credit acceptance.
    always_comb begin
        full    = (pending == LIMIT);
        nonzero = (pending != '0);
        inc     = tick && (!full || take);
    end

    // Backlog update: one up per credit, one down per start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else begin
            case ({inc, take})
                2'b10:   pending <= pending + 1'b1;
                2'b01:   pending <= pending - 1'b1;
                default: pending <= pending;
            endcase
        end
    end
endmodule

// File: rtl/refresh_row_counter.sv
// Module: refresh_row_counter
// Row address for row-addressed refresh. It wraps modulo 2**ROW_W and
// advances once per completed row-addressed cycle.
// Assumes: ROWS is a power of two.
module refresh_row_counter #(
    parameter int unsigned ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    // Step the row on each completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (adv)
            row <= row + 1'b1;
    end
endmodule

// File: rtl/refresh_seq_fsm.sv
// Module: refresh_seq_fsm
// Sequences one refresh: lead (CAS low or address set up), RAS active,
// then precharge. In CAS-first mode it chains straight from precharge
// into the next RAS pulse when another start is allowed.
// Assumes: T_LEAD, T_RAS, T_RP >= 1; can_go is computed by the arbiter.
module refresh_seq_fsm
    import refresh_pkg::*;
#(
    parameter int unsigned T_LEAD = 1,
    parameter int unsigned T_RAS  = 5,
    parameter int unsigned T_RP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_cbr,
    input  logic can_go,
    output logic take,
    output logic row_done,
    output logic ras_n,
    output logic cas_n,
    output logic addr_en,
    output logic busy
);
    localparam int unsigned TMAX = (T_LEAD > T_RAS) ?
                                   ((T_LEAD > T_RP) ? T_LEAD : T_RP) :
                                   ((T_RAS  > T_RP) ? T_RAS  : T_RP);
    localparam int unsigned CW = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LEAD_LD = CW'(T_LEAD - 1);
    localparam logic [CW-1:0] RAS_LD  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RP_LD   = CW'(T_RP - 1);

    ref_phase_e    phase, phase_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          mode_q, mode_nxt;

    // Next phase, phase timer and start/complete events.
    always_comb begin
        phase_nxt = phase;
        cnt_nxt   = cnt;
        mode_nxt  = mode_q;
        take      = 1'b0;
        row_done  = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (can_go) begin
                    phase_nxt = PH_LEAD;
                    cnt_nxt   = LEAD_LD;
                    mode_nxt  = mode_cbr;
                    take      = 1'b1;
                end
            end
            PH_LEAD: begin
                if (cnt == '0) begin
                    phase_nxt = PH_ACTIVE;
                    cnt_nxt   = RAS_LD;
                end else
                    cnt_nxt = cnt - 1'b1;
            end
            PH_ACTIVE: begin
                if (cnt == '0) begin
                    phase_nxt = PH_PRECH;
                    cnt_nxt   = RP_LD;
                end else
                    cnt_nxt = cnt - 1'b1;
            end
            PH_PRECH: begin
                if (cnt == '0) begin
                    row_done = !mode_q;
                    if (mode_q && mode_cbr && can_go) begin
                        phase_nxt = PH_ACTIVE;
                        cnt_nxt   = RAS_LD;
                        take      = 1'b1;
                    end else
                        phase_nxt = PH_IDLE;
                end else
                    cnt_nxt = cnt - 1'b1;
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Phase, timer and latched mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            phase  <= phase_nxt;
            cnt    <= cnt_nxt;
            mode_q <= mode_nxt;
        end
    end

    // Strobe and bus-ownership decode from the registered phase.
    always_comb begin
        busy    = (phase != PH_IDLE);
        ras_n   = (phase != PH_ACTIVE);
        cas_n   = !(mode_q && busy);
        addr_en = !mode_q && ((phase == PH_LEAD) || (phase == PH_ACTIVE));
    end
endmodule

// File: rtl/dram_refresh_sched.sv
// Module: dram_refresh_sched (top)
// Spreads ROWS refreshes across RETENTION_MS. It queues missed credits
// and arbitrates with the access port: refresh yields to a busy port
// unless the backlog is full.
// Assumes: CLK_KHZ*RETENTION_MS/ROWS >= 2 and ROWS is a power of two.
module dram_refresh_sched #(
    parameter int unsigned CLK_KHZ      = 50000,
    parameter int unsigned RETENTION_MS = 8,
    parameter int unsigned ROWS         = 512,
    parameter int unsigned MAX_PENDING  = 8,
    parameter int unsigned T_LEAD       = 1,
    parameter int unsigned T_RAS        = 5,
    parameter int unsigned T_RP         = 3,
    localparam int unsigned ROW_W       = $clog2(ROWS),
    localparam int unsigned PEND_W      = $clog2(MAX_PENDING + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_cbr,
    input  logic              acc_busy,
    output logic              ras_n,
    output logic              cas_n,
    output logic              addr_en,
    output logic [ROW_W-1:0]  row_addr,
    output logic [PEND_W-1:0] pending,
    output logic              ref_req,
    output logic              ref_busy,
    output logic              acc_hold
);
    localparam int unsigned INTERVAL = CLK_KHZ * RETENTION_MS / ROWS;

    logic tick, take, row_done, full, nonzero, can_go;

    refresh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    refresh_backlog #(.MAX_PENDING(MAX_PENDING), .PEND_W(PEND_W)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .take    (take),
        .pending (pending),
        .full    (full),
        .nonzero (nonzero)
    );

    // Arbitration: yield to the access port unless the backlog is full.
    always_comb begin
        can_go   = nonzero && (!acc_busy || full);
        ref_req  = nonzero;
        acc_hold = full;
    end

    refresh_seq_fsm #(.T_LEAD(T_LEAD), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_cbr (mode_cbr),
        .can_go   (can_go),
        .take     (take),
        .row_done (row_done),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .addr_en  (addr_en),
        .busy     (ref_busy)
    );

    refresh_row_counter #(.ROW_W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (row_done),
        .row   (row_addr)
    );
endmodule

// File: rtl/refresh_sched_checker.sv
// Module: refresh_sched_checker
// Protocol properties of the refresh scheduler, bound to its top.
// Assumes: connected to the top's ports only.
module refresh_sched_checker #(
    parameter int unsigned MAX_PENDING = 8,
    parameter int unsigned T_RAS       = 5,
    parameter int unsigned ROW_W       = 9,
    parameter int unsigned PEND_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_busy,
    input logic              ras_n,
    input logic              cas_n,
    input logic              addr_en,
    input logic [ROW_W-1:0]  row_addr,
    input logic [PEND_W-1:0] pending,
    input logic              ref_busy
);
    logic [15:0] low_len;

    // Length of the current RAS-low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_len <= '0;
        else if (!ras_n)
            low_len <= low_len + 1'b1;
        else
            low_len <= '0;
    end

    assert_backlog_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= PEND_W'(MAX_PENDING));

    assert_rowmode_cas_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> cas_n);

    assert_row_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n) |-> ($past(addr_en) && $stable(row_addr)));

    assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> ($past(!cas_n) && !addr_en));

    assert_ras_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_len == 16'(T_RAS) && ref_busy));

    assert_start_allowed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_busy) |-> $past((pending != '0) &&
                                  (!acc_busy || pending == PEND_W'(MAX_PENDING))));

    assert_row_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (row_addr != $past(row_addr)) |->
            ((row_addr == $past(row_addr) + 1'b1) && $past(ref_busy && cas_n)));
endmodule

bind dram_refresh_sched refresh_sched_checker #(
    .MAX_PENDING (MAX_PENDING),
    .T_RAS       (T_RAS),
    .ROW_W       (ROW_W),
    .PEND_W      (PEND_W)
) u_refresh_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_busy (acc_busy),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .addr_en  (addr_en),
    .row_addr (row_addr),
    .pending  (pending),
    .ref_busy (ref_busy)
);

// File: tb/test_dram_refresh_sched.sv
// Bench: behavioural model advanced on each rising edge, compared with
// every output on each falling edge, plus directed checks.
module test_dram_refresh_sched;
    localparam int CLK_KHZ = 1280;
    localparam int RET_MS  = 8;
    localparam int ROWS    = 512;
    localparam int MAXP    = 8;
    localparam int T_LEAD  = 1;
    localparam int T_RAS   = 5;
    localparam int T_RP    = 3;
    localparam int INTERVAL = CLK_KHZ * RET_MS / ROWS;   // 20

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_cbr = 1'b0;
    logic acc_busy = 1'b0;
    logic ras_n, cas_n, addr_en, ref_req, ref_busy, acc_hold;
    logic [8:0] row_addr;
    logic [3:0] pending;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit cmp_on   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .CLK_KHZ(CLK_KHZ), .RETENTION_MS(RET_MS), .ROWS(ROWS),
        .MAX_PENDING(MAXP), .T_LEAD(T_LEAD), .T_RAS(T_RAS), .T_RP(T_RP)
    ) i_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .mode_cbr(mode_cbr), .acc_busy(acc_busy),
        .ras_n(ras_n), .cas_n(cas_n), .addr_en(addr_en), .row_addr(row_addr),
        .pending(pending), .ref_req(ref_req), .ref_busy(ref_busy),
        .acc_hold(acc_hold)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Reference model: phase 0 idle, 1 lead, 2 RAS low, 3 precharge.
    int m_tmr, m_pend, m_ph, m_left, m_row, m_mode;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = INTERVAL - 1; m_pend = 0; m_ph = 0;
            m_left = 0; m_row = 0; m_mode = 0;
        end else begin
            bit credit, allow, start;
            credit = (m_tmr == 0);
            allow  = (m_pend > 0) && (!acc_busy || m_pend == MAXP);
            start  = 0;
            if (m_ph == 0) begin
                if (allow) begin
                    m_ph = 1; m_left = T_LEAD; m_mode = mode_cbr; start = 1;
                end
            end else begin
                m_left--;
                if (m_left == 0) begin
                    if (m_ph == 1) begin m_ph = 2; m_left = T_RAS; end
                    else if (m_ph == 2) begin m_ph = 3; m_left = T_RP; end
                    else begin
                        if (m_mode == 0) m_row = (m_row + 1) % ROWS;
                        if (m_mode == 1 && mode_cbr && allow) begin
                            m_ph = 2; m_left = T_RAS; start = 1;
                        end else
                            m_ph = 0;
                    end
                end
            end
            if (credit && (m_pend < MAXP || start)) m_pend++;
            if (start) m_pend--;
            m_tmr = credit ? INTERVAL - 1 : m_tmr - 1;
        end
    end

    // Edge counters used by the directed checks.
    int ras_falls = 0, cas_rises = 0, max_pend = 0, hold_seen = 0;
    logic ras_prev = 1'b1, cas_prev = 1'b1;

    // Full comparison with the model on every falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cmp_on) begin
            check("R6 ras_n", ras_n, (m_ph == 2) ? 0 : 1);
            check("R4 cas_n", cas_n, (m_mode == 1 && m_ph != 0) ? 0 : 1);
            check("R3 addr_en", addr_en, (m_mode == 0 && (m_ph == 1 || m_ph == 2)) ? 1 : 0);
            check("R8 row_addr", row_addr, m_row);
            check("R10 pending", pending, m_pend);
            check("R7 ref_busy", ref_busy, (m_ph != 0) ? 1 : 0);
            check("R7 ref_req", ref_req, (m_pend > 0) ? 1 : 0);
            check("R5 acc_hold", acc_hold, (m_pend == MAXP) ? 1 : 0);
            if (ras_prev && !ras_n) ras_falls++;
            if (!cas_prev && cas_n) cas_rises++;
            if (pending > max_pend) max_pend = pending;
            if (acc_hold) hold_seen = 1;
        end
        ras_prev = ras_n;
        cas_prev = cas_n;
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc >= 150000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected < %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int f0, r0, c0;
        bit found;
        logic [15:0] lfsr;
        // Reset state (R1).
        repeat (4) @(negedge clk);
        check("R1 ras_n", ras_n, 1);
        check("R1 cas_n", cas_n, 1);
        check("R1 addr_en", addr_en, 0);
        check("R1 pending", pending, 0);
        check("R1 row_addr", row_addr, 0);
        check("R1 ref_busy", ref_busy, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        check("R1 ref_req after release", ref_req, 0);
        check("R1 acc_hold after release", acc_hold, 0);

        // Row-addressed, idle port: periodic spacing and row stepping (R2, R8).
        repeat (60) @(negedge clk);
        f0 = ras_falls; r0 = row_addr;
        repeat (20 * INTERVAL) @(negedge clk);
        check("R2 RAS falls per window", ras_falls - f0, 20);
        check("R8 rows advanced", (row_addr - r0 + ROWS) % ROWS, 20);

        // CAS-first, busy port: backlog fills, forced starts (R5, R7).
        mode_cbr = 1'b1;
        acc_busy = 1'b1;
        max_pend = 0;
        repeat (15 * INTERVAL) @(negedge clk);
        check("R5 backlog peak", max_pend, MAXP);
        check("R5 hold seen at full", hold_seen, 1);

        // Release: back-to-back CAS-first drain (R9).
        f0 = ras_falls; c0 = cas_rises;
        acc_busy = 1'b0;
        repeat (8 * INTERVAL) @(negedge clk);
        check("R9 chained RAS pulses under one CAS", ((ras_falls - f0) - (cas_rises - c0)) >= 2, 1);

        // Single start decrements the backlog (R10).
        mode_cbr = 1'b0;
        acc_busy = 1'b1;
        found = 0;
        for (int i = 0; i < 20 * INTERVAL && !found; i++) begin
            @(negedge clk);
            if (pending == 2 && !ref_busy) found = 1;
        end
        check("R10 backlog reached two", found, 1);
        acc_busy = 1'b0;
        @(negedge clk);
        check("R10 pending after start", pending, 1);
        check("R7 started when port idle", ref_busy, 1);

        // Mixed traffic with mode changes.
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            acc_busy = lfsr[0] | lfsr[1];
            if (lfsr[7:2] == 6'd0) mode_cbr = ~mode_cbr;
        end
        acc_busy = 1'b0;
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule